// File: doc/BRIEF.md
# ECC-Guided Supply Speculation Controller

This block lowers a voltage domain's supply while the clock frequency stays fixed. It uses correctable ECC errors from a single weak cache line as its feedback signal. The block owns one self-test probe. Each probe writes a fixed 40-bit pattern into one line of a cache array through a request/acknowledge port. It then reads the line back and samples the correctable-error flag and the uncorrectable-error flag from the external ECC checker. Only one such controller is active per voltage domain.

Operation has two phases. In discovery (state `ST_SCAN`), the controller probes every line of the array in turn, with the set index outer and the way index inner. It latches the first line that reports a correctable error as the weak line. If a whole pass is clean, the voltage code drops by one step and the scan begins again. In the runtime phase (state `ST_WATCH`), only the weak line is probed. A window of `cfg_window` probe reads yields an error count, and that count is compared with a low and a high threshold:

- Above the high threshold, the code is raised.
- Below the low threshold, the code is lowered.
- Otherwise the code is held.

Every change of the code is followed by `ST_SETTLE`, which waits out the regulator. The transitions are:

| From | To | Name | Condition |
|---|---|---|---|
| `ST_SCAN` | `ST_WATCH` | *found* | A probe sees a correctable error |
| `ST_SCAN` | `ST_SETTLE` | *stepdown* | A clean pass moved the code |
| `ST_WATCH` | `ST_SETTLE` | *adjust* | A window decision moved the code |
| `ST_SCAN` or `ST_WATCH` | `ST_SETTLE` | *abort* | An uncorrectable error |
| `ST_SETTLE` | saved phase | *resume* | The settle count is spent |

The probe sequencer has its own states:

- `PR_IDLE` to `PR_WRITE` (*launch*)
- `PR_WRITE` to `PR_READ` (*written*)
- `PR_READ` to `PR_IDLE` (*checked*)

The voltage code is 5 mV per LSB. Code 162 is about 810 mV, and code 120 is about 600 mV.

Top module: `vspec_ctrl`

## Requirements
- R1: After reset `vcode` is the upper clamp 162, `fault` is 0, `run_phase` is 0, `vcode_upd` is 0 and no array request is pending.
- R2: A probe is a write of pattern 0x5A5A5A5A5A (`arr_we`=1) to the target line, followed by a read (`arr_we`=0) of the same line. `arr_req` and the address are held until `arr_ack`, and `arr_ce`/`arr_ue` are sampled only with the read acknowledge.
- R3: Discovery visits lines in the order set 0 way 0, set 0 way 1, and so on through the ways, then the next set. The first line whose read reports a correctable error is latched into `weak_set`/`weak_way`, and `run_phase` becomes 1.
- R4: After a discovery pass with no error, `vcode` drops by `cfg_step` (saturating at the lower clamp) and the scan restarts at set 0 way 0. At the lower clamp, repeated clean passes leave the code unchanged.
- R5: While `run_phase` is 1, every array request targets the weak line.
- R6: After `cfg_window` runtime reads (0 counts as 1), the correctable errors of the window decide the next code. A count greater than `cfg_err_hi` raises the code by `cfg_step`, and a count less than `cfg_err_lo` lowers it by `cfg_step`. Counts equal to either threshold, or between them, hold the code. The counts then restart from zero.
- R7: `vcode` never leaves the range 120 to 162; a step that would pass a clamp stops at the clamp.
- R8: Each change of `vcode` pulses `vcode_upd` for one cycle, in the first cycle carrying the new code. No array request is issued during the following `cfg_settle`+1 cycles.
- R9: A read reporting an uncorrectable error sets `vcode` to 162 on the next clock edge. On that same edge it sets `fault`, which stays 1 until reset, clears `run_phase`, and restarts discovery at set 0 way 0 after a settle interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_window | input | CW | Runtime reads per decision window |
| cfg_err_hi | input | CW | Raise when window errors exceed this |
| cfg_err_lo | input | CW | Lower when window errors fall below this |
| cfg_step | input | VW | Code change per adjustment |
| cfg_settle | input | SW | Settle wait after a code change |
| arr_ack | input | 1 | Array access complete |
| arr_ce | input | 1 | Correctable error on the read being acknowledged |
| arr_ue | input | 1 | Uncorrectable error on the read being acknowledged |
| arr_req | output | 1 | Array access request |
| arr_we | output | 1 | 1 for write, 0 for read |
| arr_set | output | SETW | Set index of the probed line |
| arr_way | output | WAYW | Way index of the probed line |
| arr_wdata | output | DW | Test pattern during writes |
| vcode | output | VW | Requested supply code |
| vcode_upd | output | 1 | One-cycle pulse when `vcode` changes |
| run_phase | output | 1 | Weak line known, runtime phase |
| weak_set | output | SETW | Set index of the weak line |
| weak_way | output | WAYW | Way index of the weak line |
| fault | output | 1 | Sticky uncorrectable-error flag |

## Verification
The bench keeps the default 4-set by 4-way array and the clamps 162/120. It sets a window of 8 reads with thresholds 2 and 4, so injected error counts of 0 through 8 per window cover every side of both thresholds, including the equal-to cases. A step of 4 makes discovery take several clean passes before the weak line at set 2 way 1 responds at code 150. Switching to a step of 40 drives the code into both clamps within single windows and down to the floor during a clean rescan. A settle of 5 cycles keeps the quiet gap visible against the probe cadence.

// File: rtl/vspec_pkg.sv
package vspec_pkg;

    typedef enum logic [1:0] {
        ST_SCAN   = 2'd0,
        ST_WATCH  = 2'd1,
        ST_SETTLE = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        PR_IDLE  = 2'd0,
        PR_WRITE = 2'd1,
        PR_READ  = 2'd2
    } probe_state_e;

    typedef enum logic [1:0] {
        VC_HOLD  = 2'd0,
        VC_UP    = 2'd1,
        VC_DOWN  = 2'd2,
        VC_FORCE = 2'd3
    } vcmd_e;

endpackage

// File: rtl/vspec_probe.sv
module vspec_probe
    import vspec_pkg::*;
#(
    parameter int SETW = 2,
    parameter int WAYW = 2,
    parameter int DW   = 40,
    parameter logic [DW-1:0] PATTERN = 40'h5A5A5A5A5A
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [SETW-1:0] tgt_set,
    input  logic [WAYW-1:0] tgt_way,
    input  logic            arr_ack,
    input  logic            arr_ce,
    input  logic            arr_ue,
    output logic            arr_req,
    output logic            arr_we,
    output logic [SETW-1:0] arr_set,
    output logic [WAYW-1:0] arr_way,
    output logic [DW-1:0]   arr_wdata,
    output logic            done,
    output logic            done_ce,
    output logic            done_ue
);

    probe_state_e ps, ps_nxt;
    logic [SETW-1:0] lat_set;
    logic [WAYW-1:0] lat_way;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) ps <= PR_IDLE;
        else        ps <= ps_nxt;
    end

    always_comb begin
        ps_nxt = ps;
        unique case (ps)
            PR_IDLE:  if (go)      ps_nxt = PR_WRITE;  // launch
            PR_WRITE: if (arr_ack) ps_nxt = PR_READ;   // written
            PR_READ:  if (arr_ack) ps_nxt = PR_IDLE;   // checked
            default:               ps_nxt = PR_IDLE;
        endcase
    end

    // target is frozen for the whole probe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_set <= '0;
            lat_way <= '0;
        end else if (ps == PR_IDLE && go) begin
            lat_set <= tgt_set;
            lat_way <= tgt_way;
        end
    end

    // outputs
    always_comb begin
        arr_req   = (ps != PR_IDLE);
        arr_we    = (ps == PR_WRITE);
        arr_set   = lat_set;
        arr_way   = lat_way;
        arr_wdata = (ps == PR_WRITE) ? PATTERN : '0;
        done      = (ps == PR_READ) && arr_ack;
        done_ce   = done && arr_ce;
        done_ue   = done && arr_ue;
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_ack) |=> (arr_req && $stable(arr_set) && $stable(arr_way) && $stable(arr_we)));

    assert_read_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_we && arr_ack) |=> (arr_req && !arr_we && $stable(arr_set) && $stable(arr_way)));

    assert_done_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !arr_req);

endmodule

// File: rtl/vspec_rate.sv
module vspec_rate
    import vspec_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sample,
    input  logic          sample_ce,
    input  logic [CW-1:0] cfg_window,
    input  logic [CW-1:0] cfg_err_hi,
    input  logic [CW-1:0] cfg_err_lo,
    output logic          win_end,
    output vcmd_e         verdict
);

    logic [CW-1:0] acc_cnt, err_cnt;
    logic [CW-1:0] acc_inc, err_inc, win_len;

    always_comb begin
        win_len = (cfg_window == '0) ? CW'(1) : cfg_window;
        acc_inc = acc_cnt + CW'(1);
        err_inc = err_cnt + CW'(sample_ce);
        win_end = sample && (acc_inc >= win_len);
        if (err_inc > cfg_err_hi)      verdict = VC_UP;
        else if (err_inc < cfg_err_lo) verdict = VC_DOWN;
        else                           verdict = VC_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr || win_end) begin
            acc_cnt <= '0;
            err_cnt <= '0;
        end else if (sample) begin
            acc_cnt <= acc_inc;
            err_cnt <= err_inc;
        end
    end

    assert_window_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (acc_cnt == '0 && err_cnt == '0));

    assert_errors_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= acc_cnt);

endmodule

// File: rtl/vspec_vcode.sv
module vspec_vcode
    import vspec_pkg::*;
#(
    parameter int VW        = 8,
    parameter int VCODE_MAX = 162,
    parameter int VCODE_MIN = 120
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vcmd_e         cmd,
    input  logic [VW-1:0] step,
    output logic [VW-1:0] code,
    output logic          moving,
    output logic          upd
);

    localparam logic [VW-1:0] LIM_HI = VW'(VCODE_MAX);
    localparam logic [VW-1:0] LIM_LO = VW'(VCODE_MIN);

    logic [VW-1:0] code_nxt;

    always_comb begin
        code_nxt = code;
        unique case (cmd)
            VC_UP:    code_nxt = (step >= (LIM_HI - code)) ? LIM_HI : code + step;
            VC_DOWN:  code_nxt = (step >= (code - LIM_LO)) ? LIM_LO : code - step;
            VC_FORCE: code_nxt = LIM_HI;
            default:  code_nxt = code;
        endcase
        moving = (code_nxt != code);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= LIM_HI;
            upd  <= 1'b0;
        end else begin
            code <= code_nxt;
            upd  <= moving;
        end
    end

    assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= LIM_LO) && (code <= LIM_HI));

    assert_force_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == VC_FORCE) |=> (code == LIM_HI));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == VC_HOLD) |=> $stable(code));

    assert_upd_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (code != $past(code)));

endmodule

// File: rtl/vspec_ctrl.sv
module vspec_ctrl
    import vspec_pkg::*;
#(
    parameter int SETS      = 4,
    parameter int WAYS      = 4,
    parameter int DW        = 40,
    parameter logic [DW-1:0] PATTERN = 40'h5A5A5A5A5A,
    parameter int VW        = 8,
    parameter int VCODE_MAX = 162,
    parameter int VCODE_MIN = 120,
    parameter int CW        = 16,
    parameter int SW        = 16,
    localparam int SETW     = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAYW     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   cfg_window,
    input  logic [CW-1:0]   cfg_err_hi,
    input  logic [CW-1:0]   cfg_err_lo,
    input  logic [VW-1:0]   cfg_step,
    input  logic [SW-1:0]   cfg_settle,
    input  logic            arr_ack,
    input  logic            arr_ce,
    input  logic            arr_ue,
    output logic            arr_req,
    output logic            arr_we,
    output logic [SETW-1:0] arr_set,
    output logic [WAYW-1:0] arr_way,
    output logic [DW-1:0]   arr_wdata,
    output logic [VW-1:0]   vcode,
    output logic            vcode_upd,
    output logic            run_phase,
    output logic [SETW-1:0] weak_set,
    output logic [WAYW-1:0] weak_way,
    output logic            fault
);

    localparam logic [SETW-1:0] LAST_SET = SETW'(SETS - 1);
    localparam logic [WAYW-1:0] LAST_WAY = WAYW'(WAYS - 1);

    ctl_state_e st, st_nxt, ret_st;
    logic [SETW-1:0] scan_set, tgt_set;
    logic [WAYW-1:0] scan_way, tgt_way;
    logic [SW-1:0]   settle_cnt;
    logic            weak_valid;
    logic            last_line;
    logic            pr_go, pr_done, pr_ce, pr_ue;
    logic            win_end, rate_clr, rate_sample, vc_move;
    vcmd_e           verdict, vcmd;

    // probe target selection
    always_comb begin
        pr_go     = (st != ST_SETTLE);
        tgt_set   = (st == ST_WATCH) ? weak_set : scan_set;
        tgt_way   = (st == ST_WATCH) ? weak_way : scan_way;
        last_line = (scan_set == LAST_SET) && (scan_way == LAST_WAY);
    end

    vspec_probe #(
        .SETW(SETW), .WAYW(WAYW), .DW(DW), .PATTERN(PATTERN)
    ) u_probe (
        .clk(clk), .rst_n(rst_n), .go(pr_go),
        .tgt_set(tgt_set), .tgt_way(tgt_way),
        .arr_ack(arr_ack), .arr_ce(arr_ce), .arr_ue(arr_ue),
        .arr_req(arr_req), .arr_we(arr_we),
        .arr_set(arr_set), .arr_way(arr_way), .arr_wdata(arr_wdata),
        .done(pr_done), .done_ce(pr_ce), .done_ue(pr_ue)
    );

    always_comb begin
        rate_sample = pr_done && (st == ST_WATCH) && !pr_ue;
        rate_clr    = (st != ST_WATCH) || pr_ue;
    end

    vspec_rate #(.CW(CW)) u_rate (
        .clk(clk), .rst_n(rst_n), .clr(rate_clr),
        .sample(rate_sample), .sample_ce(pr_ce),
        .cfg_window(cfg_window), .cfg_err_hi(cfg_err_hi), .cfg_err_lo(cfg_err_lo),
        .win_end(win_end), .verdict(verdict)
    );

    // voltage command
    always_comb begin
        if (pr_ue)
            vcmd = VC_FORCE;
        else if (st == ST_SCAN && pr_done && !pr_ce && last_line)
            vcmd = VC_DOWN;
        else if (st == ST_WATCH && win_end)
            vcmd = verdict;
        else
            vcmd = VC_HOLD;
    end

    vspec_vcode #(
        .VW(VW), .VCODE_MAX(VCODE_MAX), .VCODE_MIN(VCODE_MIN)
    ) u_vcode (
        .clk(clk), .rst_n(rst_n), .cmd(vcmd), .step(cfg_step),
        .code(vcode), .moving(vc_move), .upd(vcode_upd)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_SCAN;
        else        st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_SCAN: begin
                if (pr_done) begin
                    if (pr_ue)                  st_nxt = ST_SETTLE;  // abort
                    else if (pr_ce)             st_nxt = ST_WATCH;   // found
                    else if (last_line && vc_move) st_nxt = ST_SETTLE; // stepdown
                end
            end
            ST_WATCH: begin
                if (pr_ue)                      st_nxt = ST_SETTLE;  // abort
                else if (win_end && vc_move)    st_nxt = ST_SETTLE;  // adjust
            end
            ST_SETTLE: begin
                if (settle_cnt == '0)           st_nxt = ret_st;     // resume
            end
            default:                            st_nxt = ST_SCAN;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_set   <= '0;
            scan_way   <= '0;
            weak_set   <= '0;
            weak_way   <= '0;
            weak_valid <= 1'b0;
            fault      <= 1'b0;
            settle_cnt <= '0;
            ret_st     <= ST_SCAN;
        end else if (pr_ue) begin
            fault      <= 1'b1;
            weak_valid <= 1'b0;
            scan_set   <= '0;
            scan_way   <= '0;
            settle_cnt <= cfg_settle;
            ret_st     <= ST_SCAN;
        end else begin
            case (st)
                ST_SCAN: begin
                    if (pr_done) begin
                        if (pr_ce) begin
                            weak_set   <= scan_set;
                            weak_way   <= scan_way;
                            weak_valid <= 1'b1;
                            scan_set   <= '0;
                            scan_way   <= '0;
                        end else if (last_line) begin
                            scan_set   <= '0;
                            scan_way   <= '0;
                            settle_cnt <= cfg_settle;
                            ret_st     <= ST_SCAN;
                        end else if (scan_way == LAST_WAY) begin
                            scan_way <= '0;
                            scan_set <= scan_set + SETW'(1);
                        end else begin
                            scan_way <= scan_way + WAYW'(1);
                        end
                    end
                end
                ST_WATCH: begin
                    if (win_end && vc_move) begin
                        settle_cnt <= cfg_settle;
                        ret_st     <= ST_WATCH;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt != '0) settle_cnt <= settle_cnt - SW'(1);
                end
                default: ;
            endcase
        end
    end

    assign run_phase = weak_valid;

    assert_settle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE) |-> !arr_req);

    assert_change_settles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vcode_upd |-> (st == ST_SETTLE));

    assert_run_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (weak_valid && arr_req) |-> (arr_set == weak_set && arr_way == weak_way));

    assert_ue_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pr_ue |=> (vcode == VW'(VCODE_MAX) && fault && !weak_valid && st == ST_SETTLE));

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    assert_found_enters_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(weak_valid) |-> (st == ST_WATCH));

endmodule

// File: tb/vspec_ctrl_test.sv
module vspec_ctrl_test;

    localparam int WIN  = 8;
    localparam int HI   = 4;
    localparam int LO   = 2;
    localparam int SETL = 5;
    localparam int TOP  = 162;
    localparam int BOT  = 120;
    localparam logic [39:0] PAT = 40'h5A5A5A5A5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_window = 16'(WIN);
    logic [15:0] cfg_err_hi = 16'(HI);
    logic [15:0] cfg_err_lo = 16'(LO);
    logic [7:0]  cfg_step   = 8'd4;
    logic [15:0] cfg_settle = 16'(SETL);
    logic        arr_ack = 1'b0, arr_ce = 1'b0, arr_ue = 1'b0;
    logic        arr_req, arr_we, vcode_upd, run_phase, fault;
    logic [1:0]  arr_set, arr_way, weak_set, weak_way;
    logic [39:0] arr_wdata;
    logic [7:0]  vcode;

    vspec_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_window(cfg_window), .cfg_err_hi(cfg_err_hi), .cfg_err_lo(cfg_err_lo),
        .cfg_step(cfg_step), .cfg_settle(cfg_settle),
        .arr_ack(arr_ack), .arr_ce(arr_ce), .arr_ue(arr_ue),
        .arr_req(arr_req), .arr_we(arr_we), .arr_set(arr_set), .arr_way(arr_way),
        .arr_wdata(arr_wdata), .vcode(vcode), .vcode_upd(vcode_upd),
        .run_phase(run_phase), .weak_set(weak_set), .weak_way(weak_way), .fault(fault)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- array / ECC model ----------------
    bit line_on = 1'b1;       // line set 2 way 1 errs when vcode <= 150
    int inj_k   = 0;          // runtime: first inj_k reads of each window err
    int ue_req  = 0;
    int ue_done = 0;
    int rd_run  = 0;          // reads completed in runtime phase

    always @(posedge clk) begin
        arr_ack <= 1'b0;
        arr_ce  <= 1'b0;
        arr_ue  <= 1'b0;
        if (arr_req && !arr_ack) begin
            arr_ack <= 1'b1;
            if (!arr_we) begin
                if (run_phase)
                    arr_ce <= ((rd_run % WIN) < inj_k);
                else
                    arr_ce <= line_on && arr_set == 2'd2 && arr_way == 2'd1 && vcode <= 8'd150;
                if (ue_req != ue_done) begin
                    arr_ue  <= 1'b1;
                    ue_done <= ue_done + 1;
                end
            end
        end
        if (!run_phase) rd_run <= 0;
        else if (arr_ack && !arr_we) rd_run <= rd_run + 1;
    end

    // ---------------- monitors ----------------
    int wr_n = 0, order_bad = 0, wd_bad = 0, pair_bad = 0, run_bad = 0;
    logic [1:0] last_ws = '0, last_ww = '0, cap_set = '1, cap_way = '1;
    bit cap_done = 1'b0;

    always @(posedge clk) begin
        if (rst_n && arr_req && !arr_ack) begin
            if (arr_we) begin
                if (wr_n < 16 && (int'(arr_set) != wr_n / 4 || int'(arr_way) != wr_n % 4))
                    order_bad <= order_bad + 1;
                wr_n <= wr_n + 1;
                if (arr_wdata != PAT) wd_bad <= wd_bad + 1;
                last_ws <= arr_set;
                last_ww <= arr_way;
                if (fault && !cap_done) begin
                    cap_set  <= arr_set;
                    cap_way  <= arr_way;
                    cap_done <= 1'b1;
                end
            end else if (arr_set != last_ws || arr_way != last_ww) begin
                pair_bad <= pair_bad + 1;
            end
            if (run_phase && (arr_set != 2'd2 || arr_way != 2'd1)) run_bad <= run_bad + 1;
        end
    end

    int gap = 0, gap_bad = 0, upd_cnt = 0, min_code = 255;
    bit gap_on = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(vcode) < min_code) min_code = int'(vcode);
            if (vcode_upd) begin
                upd_cnt++;
                if (arr_req) gap_bad++;
                gap = 1;
                gap_on = 1'b1;
            end else if (gap_on) begin
                if (arr_req) begin
                    if (gap < SETL + 1) gap_bad++;
                    gap_on = 1'b0;
                end else begin
                    gap++;
                end
            end
        end
    end

    // runtime vectors: {step, errors in window, expected code}
    localparam int NV = 13;
    localparam int VEC [NV][3] = '{
        '{ 4, 0, 146}, '{ 4, 3, 146}, '{ 4, 5, 150}, '{ 4, 2, 150},
        '{ 4, 4, 150}, '{ 4, 1, 146}, '{ 4, 8, 150}, '{40, 0, 120},
        '{40, 0, 120}, '{40, 8, 160}, '{40, 8, 162}, '{40, 8, 162},
        '{40, 0, 122}
    };

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(vcode == 8'(TOP), "R1 vcode", int'(vcode), TOP);
        check(!fault && !run_phase && !vcode_upd, "R1 flags", int'({fault, run_phase, vcode_upd}), 0);
        check(!arr_req, "R1 no request", int'(arr_req), 0);
        rst_n = 1'b1;

        // R3/R4 discovery: clean passes at 162,158,154, line (2,1) errs at 150
        wait (run_phase == 1'b1);
        @(negedge clk);
        check(order_bad == 0, "R3 scan order", order_bad, 0);
        check(wd_bad == 0 && pair_bad == 0, "R2 write pattern then read same line", wd_bad + pair_bad, 0);
        check(vcode == 8'd150, "R4 stepped down by clean passes", int'(vcode), 150);
        check(weak_set == 2'd2 && weak_way == 2'd1, "R3 weak line", int'({weak_set, weak_way}), 9);
        check(upd_cnt == 3, "R8 one pulse per change", upd_cnt, 3);

        // R6/R7 runtime window decisions
        for (int i = 0; i < NV; i++) begin
            int target;
            int pulses;
            int prev;
            prev     = int'(vcode);
            pulses   = upd_cnt;
            cfg_step = 8'(VEC[i][0]);
            inj_k    = VEC[i][1];
            target   = rd_run + WIN;
            wait (rd_run >= target);
            @(negedge clk);
            @(negedge clk);
            check(int'(vcode) == VEC[i][2], $sformatf("R6 R7 window %0d code", i), int'(vcode), VEC[i][2]);
            check((upd_cnt - pulses) == ((VEC[i][2] != prev) ? 1 : 0),
                  $sformatf("R8 window %0d pulse", i), upd_cnt - pulses, (VEC[i][2] != prev) ? 1 : 0);
        end
        check(run_bad == 0, "R5 runtime targets weak line", run_bad, 0);

        // R9 uncorrectable error at code 122
        cfg_step = 8'd4;
        inj_k    = 3;
        ue_req   = ue_req + 1;
        wait (ue_done == ue_req);
        @(posedge clk);
        @(negedge clk);
        check(vcode == 8'(TOP), "R9 forced to top", int'(vcode), TOP);
        check(fault && !run_phase, "R9 fault set, discovery", int'({fault, run_phase}), 2);
        wait (run_phase == 1'b1);
        @(negedge clk);
        check(cap_done && cap_set == 2'd0 && cap_way == 2'd0, "R9 rescan from line 0",
              int'({cap_set, cap_way}), 0);
        check(vcode == 8'd150 && weak_set == 2'd2 && weak_way == 2'd1, "R3 rediscovery",
              int'(vcode), 150);
        check(fault, "R9 fault sticky", int'(fault), 1);

        // R4/R7 clean rescans descend to floor and stop there
        line_on  = 1'b0;
        cfg_step = 8'd40;
        ue_req   = ue_req + 1;
        wait (ue_done == ue_req);
        repeat (900) @(posedge clk);
        @(negedge clk);
        check(vcode == 8'(BOT), "R4 floor reached by clean passes", int'(vcode), BOT);
        check(min_code >= BOT, "R7 never below floor", min_code, BOT);
        check(!run_phase && fault, "R4 still scanning", int'({fault, run_phase}), 2);
        check(gap_bad == 0, "R8 settle gap", gap_bad, 0);
        check(run_bad == 0 && pair_bad == 0, "R5 R2 targets", run_bad + pair_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule